// File: doc/BRIEF.md
# Register-Load Command Parser

This block sits on a 32-bit command dword stream with a valid/ready handshake. It watches for register-load commands and passes over every other dword. Each such command is a header followed by a list of address/value pairs. For each pair the block issues one write on a simple register write port that has address, data and valid/ready. The header can select an engine-relative mode, in which each offset is added to a per-engine base. The header also carries a posted-write hint, which is forwarded with every write of that command.

Two header problems are detected and latched. A length field that cannot be a legal pair count is one; the parser then drops the whole payload. A command that was not directly preceded by an all-zero no-op dword is the other; the writes of that command still go out. Both flags stay set until reset.

Top module: `lri_parser`

## Requirements
- R1: A dword accepted between commands is a register-load header only when bits 31:29 are 0 and bits 28:23 equal 0x22. Any other dword is consumed and causes no write.
- R2: The header's bits 7:0 hold 2N-1, where N is the number of pairs. Each pair is an address dword followed by a data dword and yields exactly one write, issued in stream order, with wrData equal to the data dword.
- R3: Bits 1:0 of each address dword are cleared. With header bit 19 at 0, wrAddr is that cleared offset in full, whatever ctxRestore is.
- R4: With header bit 19 at 1, wrAddr is engineBase plus the cleared offset, modulo 2^ADDR_W.
- R5: When header bit 19 is 1 and ctxRestore is high as the header is accepted, the offset is further reduced to its bits 12:2 (mask 0x1FFC) before the base is added.
- R6: Header bit 12 appears on wrPosted for every write of that command.
- R7: A header whose length field is even or above 251 sets the sticky lenErr. The parser then consumes length+1 further dwords without decoding them and issues no write for them.
- R8: A command of 126 pairs (length 251) is legal and yields 126 writes.
- R9: A header whose previous accepted dword was not all-zero sets the sticky orderErr, and its writes are still issued. Payload dwords and non-command dwords never count as the preceding no-op.
- R10: While a write waits for wrReady, cmdReady is low and wrAddr, wrData and wrPosted hold.
- R11: After reset, cmdReady is 1, and wrValid, lenErr and orderErr are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmdData | input | 32 | Command stream dword |
| cmdValid | input | 1 | Stream dword valid |
| cmdReady | output | 1 | Parser can take a dword |
| engineBase | input | ADDR_W | Base added in engine-relative mode |
| ctxRestore | input | 1 | Context restore in progress, sampled with the header |
| wrAddr | output | ADDR_W | Register write address |
| wrData | output | 32 | Register write data |
| wrPosted | output | 1 | Posted-write hint of the current command |
| wrValid | output | 1 | Write request valid |
| wrReady | input | 1 | Write port accepts the request |
| lenErr | output | 1 | Sticky illegal-length flag |
| orderErr | output | 1 | Sticky missing-no-op flag |

## Verification
A single header can raise both flags on the same clock edge. This happens when its length is illegal and it also follows a non-zero dword. The bench sends such a header directly after reset. It first confirms that both flags are low, then finds both set in the sample taken just after that header is accepted, and then checks that the skipped payload produced no write. A second overlap arises when a stalled write meets the next offered address dword. Here wrReady is toggled every cycle, and the bench confirms that cmdReady stays low for as long as wrValid is high and that the written values match the pairs.

// File: rtl/lri_pkg.sv
package lri_pkg;
  localparam int WORD_W     = 32;
  localparam int LEN_W      = 8;
  localparam int REL_BIT    = 19;
  localparam int POSTED_BIT = 12;
  localparam logic [2:0] CLIENT_CMD = 3'd0;
  localparam logic [5:0] OPC_LOAD   = 6'h22;
  localparam logic [31:0] RESTORE_MASK = 32'h0000_1FFC;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_DATA, ST_ISSUE, ST_SKIP
  } parseState_t;

  typedef struct packed {
    logic loadHdr;
    logic loadAddr;
    logic loadData;
  } dpStrobe_t;
endpackage

// File: rtl/lri_ctrl.sv
module lri_ctrl
  import lri_pkg::*;
#(
  parameter int MAX_PAIRS = 126
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cmdData,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              wrReady,
  output logic              wrValid,
  output dpStrobe_t         strobe,
  output logic              lenErr,
  output logic              orderErr
);
  localparam int MAX_LEN = 2 * MAX_PAIRS - 1;
  localparam int CNT_W   = LEN_W + 1;

  parseState_t state;
  logic [CNT_W-1:0] cnt;
  logic prevNoop;

  logic accept, isLoad, lenBad;
  logic [LEN_W-1:0] lenField;
  logic [CNT_W-1:0] skipCnt, pairCnt;

  assign cmdReady = (state != ST_ISSUE);
  assign wrValid  = (state == ST_ISSUE);
  assign accept   = cmdValid && cmdReady;
  assign isLoad   = (cmdData[31:29] == CLIENT_CMD) && (cmdData[28:23] == OPC_LOAD);
  assign lenField = cmdData[LEN_W-1:0];
  assign lenBad   = !lenField[0] || (int'(lenField) > MAX_LEN);
  assign skipCnt  = {1'b0, lenField} + CNT_W'(1);
  assign pairCnt  = skipCnt >> 1;

  always_comb begin
    strobe          = '0;
    strobe.loadHdr  = (state == ST_IDLE) && accept && isLoad && !lenBad;
    strobe.loadAddr = (state == ST_ADDR) && accept;
    strobe.loadData = (state == ST_DATA) && accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      prevNoop <= 1'b0;
      lenErr   <= 1'b0;
      orderErr <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          if (isLoad) begin
            prevNoop <= 1'b0;
            if (!prevNoop) orderErr <= 1'b1;
            if (lenBad) begin
              lenErr <= 1'b1;
              cnt    <= skipCnt;
              state  <= ST_SKIP;
            end else begin
              cnt   <= pairCnt;
              state <= ST_ADDR;
            end
          end else begin
            prevNoop <= (cmdData == '0);
          end
        end
        ST_ADDR:  if (accept) state <= ST_DATA;
        ST_DATA:  if (accept) state <= ST_ISSUE;
        ST_ISSUE: if (wrReady) begin
          cnt   <= cnt - CNT_W'(1);
          state <= (cnt == CNT_W'(1)) ? ST_IDLE : ST_ADDR;
        end
        ST_SKIP: if (accept) begin
          cnt <= cnt - CNT_W'(1);
          if (cnt == CNT_W'(1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lri_datapath.sv
module lri_datapath
  import lri_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] cmdData,
  input  logic [ADDR_W-1:0] engineBase,
  input  logic              ctxRestore,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [WORD_W-1:0] wrData,
  output logic              wrPosted
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

  logic relMode, maskMode;
  logic [ADDR_W-1:0] offClr, offUse;

  assign offClr = ADDR_W'(cmdData) & ALIGN_MASK;
  assign offUse = maskMode ? (offClr & ADDR_W'(RESTORE_MASK)) : offClr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      relMode  <= 1'b0;
      maskMode <= 1'b0;
      wrPosted <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      if (strobe.loadHdr) begin
        relMode  <= cmdData[REL_BIT];
        maskMode <= cmdData[REL_BIT] && ctxRestore;
        wrPosted <= cmdData[POSTED_BIT];
      end
      if (strobe.loadAddr)
        wrAddr <= relMode ? (engineBase + offUse) : offUse;
      if (strobe.loadData)
        wrData <= cmdData;
    end
  end
endmodule

// File: rtl/lri_parser.sv
module lri_parser
  import lri_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_PAIRS = 126
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cmdData,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [ADDR_W-1:0] engineBase,
  input  logic              ctxRestore,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [31:0]       wrData,
  output logic              wrPosted,
  output logic              wrValid,
  input  logic              wrReady,
  output logic              lenErr,
  output logic              orderErr
);
  dpStrobe_t strobe;

  lri_ctrl #(.MAX_PAIRS(MAX_PAIRS)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdData(cmdData), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .wrReady(wrReady), .wrValid(wrValid),
    .strobe(strobe), .lenErr(lenErr), .orderErr(orderErr)
  );

  lri_datapath #(.ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cmdData(cmdData),
    .engineBase(engineBase), .ctxRestore(ctxRestore),
    .wrAddr(wrAddr), .wrData(wrData), .wrPosted(wrPosted)
  );
endmodule

// File: rtl/lri_parser_chk.sv
module lri_parser_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [31:0]       wrData,
  input logic              wrPosted,
  input logic              wrValid,
  input logic              wrReady,
  input logic              lenErr,
  input logic              orderErr
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && !wrReady) |=> (wrValid && $stable({wrAddr, wrData, wrPosted})));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrValid |-> !cmdReady);

  p_sticky_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lenErr |=> lenErr);

  p_sticky_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    orderErr |=> orderErr);

  p_len_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lenErr) |-> $past(cmdValid && cmdReady));

  p_order_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(orderErr) |-> $past(cmdValid && cmdReady));
endmodule

bind lri_parser lri_parser_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .wrAddr(wrAddr), .wrData(wrData), .wrPosted(wrPosted), .wrValid(wrValid),
  .wrReady(wrReady), .lenErr(lenErr), .orderErr(orderErr)
);

// File: tb/test_lri_parser.sv
module test_lri_parser;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] cmdData = '0;
  logic cmdValid = 1'b0;
  logic cmdReady;
  logic [31:0] engineBase = '0;
  logic ctxRestore = 1'b0;
  logic [31:0] wrAddr, wrData;
  logic wrPosted, wrValid;
  logic wrReady = 1'b1;
  logic lenErr, orderErr;

  int nChecks = 0;
  int nFail = 0;

  lri_parser i_lri_parser (
    .clk(clk), .rst_n(rst_n), .cmdData(cmdData), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .engineBase(engineBase), .ctxRestore(ctxRestore),
    .wrAddr(wrAddr), .wrData(wrData), .wrPosted(wrPosted), .wrValid(wrValid),
    .wrReady(wrReady), .lenErr(lenErr), .orderErr(orderErr)
  );

  always #10 clk = ~clk;

  // write monitor and wrReady driver
  logic [31:0] capAddr [0:1023];
  logic [31:0] capData [0:1023];
  logic        capPost [0:1023];
  int capN = 0;
  int holdViol = 0;
  logic bpOn = 1'b0;
  logic bpPhase = 1'b0;

  always @(negedge clk) begin
    logic nr;
    if (bpOn) begin
      bpPhase = ~bpPhase;
      nr = bpPhase;
    end else begin
      nr = 1'b1;
    end
    if (wrValid && cmdReady) holdViol++;
    if (wrValid && nr && capN < 1024) begin
      capAddr[capN] = wrAddr;
      capData[capN] = wrData;
      capPost[capN] = wrPosted;
      capN++;
    end
    wrReady = nr;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input int n, input bit rel, input bit posted);
    return 32'h1100_0000 | (32'(rel) << 19) | (32'(posted) << 12) | 32'(2 * n - 1);
  endfunction

  function automatic logic [31:0] expA(input logic [31:0] off, input bit rel,
                                       input bit rstr, input logic [31:0] base);
    logic [31:0] o;
    o = off & 32'hFFFF_FFFC;
    if (rel && rstr) o = o & 32'h0000_1FFC;
    return rel ? base + o : o;
  endfunction

  task automatic sendDword(input logic [31:0] d);
    cmdData  = d;
    cmdValid = 1'b1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic drain();
    repeat (8) @(negedge clk);
  endtask

  task automatic doReset();
    cmdValid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // sends a command of n pairs and checks resulting writes
  task automatic runCmd(input string req, input int n, input bit rel,
                        input bit posted, input logic [31:0] offs [4],
                        input logic [31:0] vals [4]);
    int start;
    int bad;
    start = capN;
    bad = 0;
    sendDword(hdr(n, rel, posted));
    for (int i = 0; i < n; i++) begin
      sendDword(offs[i]);
      sendDword(vals[i]);
    end
    drain();
    check(capN - start == n, req, "write count", 32'(capN - start), 32'(n));
    for (int i = 0; i < n && start + i < capN; i++) begin
      check(capAddr[start + i] == expA(offs[i], rel, ctxRestore, engineBase), req,
            "wrAddr", capAddr[start + i], expA(offs[i], rel, ctxRestore, engineBase));
      check(capData[start + i] == vals[i], "R2", "wrData", capData[start + i], vals[i]);
      check(capPost[start + i] == posted, "R6", "wrPosted",
            32'(capPost[start + i]), 32'(posted));
    end
  endtask

  task automatic tReset();
    check(cmdReady == 1'b1, "R11", "cmdReady", 32'(cmdReady), 32'd1);
    check(wrValid == 1'b0, "R11", "wrValid", 32'(wrValid), 32'd0);
    check(lenErr == 1'b0, "R11", "lenErr", 32'(lenErr), 32'd0);
    check(orderErr == 1'b0, "R11", "orderErr", 32'(orderErr), 32'd0);
  endtask

  task automatic tAbsolute();
    logic [31:0] o [4] = '{32'h0000_2003, 32'h1234_567A, 32'h0, 32'h0};
    logic [31:0] v [4] = '{32'hDEAD_BEEF, 32'h0BAD_F00D, 32'h0, 32'h0};
    doReset();
    ctxRestore = 1'b1;  // R3: absolute mode ignores restore masking
    sendDword(32'h0);
    runCmd("R3", 2, 1'b0, 1'b0, o, v);
    check(orderErr == 1'b0, "R9", "orderErr after no-op", 32'(orderErr), 32'd0);
    check(lenErr == 1'b0, "R2", "lenErr legal length", 32'(lenErr), 32'd0);
    ctxRestore = 1'b0;
  endtask

  task automatic tRelative();
    logic [31:0] o [4] = '{32'h0000_2204, 32'h0001_E00B, 32'h0000_0010, 32'h0};
    logic [31:0] v [4] = '{32'h1111_0001, 32'h2222_0002, 32'h3333_0003, 32'h0};
    doReset();
    engineBase = 32'h0003_0000;
    ctxRestore = 1'b0;
    sendDword(32'h0);
    runCmd("R4", 3, 1'b1, 1'b1, o, v);
    // R5: restore masking
    ctxRestore = 1'b1;
    sendDword(32'h0);
    runCmd("R5", 2, 1'b1, 1'b0, o, v);
    ctxRestore = 1'b0;
    engineBase = 32'hFFFF_FFF0;  // R4 wraparound
    sendDword(32'h0);
    runCmd("R4", 1, 1'b1, 1'b1, '{32'h0000_0020, 32'h0, 32'h0, 32'h0},
           '{32'h5A5A_5A5A, 32'h0, 32'h0, 32'h0});
    engineBase = '0;
  endtask

  // both flags raised by one header
  task automatic tBothFlags();
    int start;
    doReset();
    check(lenErr == 1'b0 && orderErr == 1'b0, "R7", "flags before header",
          {30'b0, lenErr, orderErr}, 32'd0);
    start = capN;
    sendDword(32'h1100_0004);  // even length, no preceding no-op
    check(lenErr == 1'b1, "R7", "lenErr same edge", 32'(lenErr), 32'd1);
    check(orderErr == 1'b1, "R9", "orderErr same edge", 32'(orderErr), 32'd1);
    for (int i = 0; i < 5; i++) sendDword(hdr(1, 1'b0, 1'b0));
    drain();
    check(capN == start, "R7", "no write from skipped payload", 32'(capN - start), 32'd0);
  endtask

  task automatic tSkipExact();
    int start;
    doReset();
    start = capN;
    sendDword(32'h0);
    sendDword(32'h1100_0002);  // skip 3
    sendDword(hdr(1, 1'b0, 1'b0));
    sendDword(32'h0000_0100);
    sendDword(32'h0000_0055);
    sendDword(32'h0);
    sendDword(hdr(1, 1'b0, 1'b0));
    sendDword(32'h0000_0040);
    sendDword(32'h0000_0007);
    drain();
    check(lenErr == 1'b1, "R7", "lenErr even length", 32'(lenErr), 32'd1);
    check(orderErr == 1'b0, "R7", "skip length exact", 32'(orderErr), 32'd0);
    check(capN - start == 1, "R7", "writes after skip", 32'(capN - start), 32'd1);
    if (capN - start >= 1)
      check(capAddr[start] == 32'h40, "R7", "post-skip addr", capAddr[start], 32'h40);
  endtask

  task automatic tTooLong();
    int start;
    doReset();
    start = capN;
    sendDword(32'h0);
    sendDword(32'h1100_00FD);  // 253: too many pairs, skip 254
    for (int i = 0; i < 254; i++) sendDword(hdr(1, 1'b0, 1'b0));
    sendDword(32'h0);
    sendDword(hdr(1, 1'b0, 1'b0));
    sendDword(32'h0000_0080);
    sendDword(32'h0000_0009);
    drain();
    check(lenErr == 1'b1, "R7", "lenErr over limit", 32'(lenErr), 32'd1);
    check(orderErr == 1'b0, "R7", "long skip exact", 32'(orderErr), 32'd0);
    check(capN - start == 1, "R7", "writes after long skip", 32'(capN - start), 32'd1);
  endtask

  task automatic tMax();
    int start;
    int bad;
    doReset();
    start = capN;
    bad = 0;
    sendDword(32'h0);
    sendDword(32'h1100_00FB);
    for (int i = 0; i < 126; i++) begin
      sendDword(32'(i * 4));
      sendDword(32'hA5A5_0000 ^ 32'(i));
    end
    drain();
    check(lenErr == 1'b0, "R8", "lenErr at 126 pairs", 32'(lenErr), 32'd0);
    check(capN - start == 126, "R8", "write count", 32'(capN - start), 32'd126);
    for (int i = 0; i < 126 && start + i < capN; i++)
      if (capAddr[start + i] != 32'(i * 4) || capData[start + i] != (32'hA5A5_0000 ^ 32'(i)))
        bad++;
    check(bad == 0, "R8", "pair contents", 32'(bad), 32'd0);
  endtask

  task automatic tBackpressure();
    logic [31:0] o [4] = '{32'h0000_0104, 32'h0000_0208, 32'h0000_030C, 32'h0000_0410};
    logic [31:0] v [4] = '{32'hC0DE_0001, 32'hC0DE_0002, 32'hC0DE_0003, 32'hC0DE_0004};
    doReset();
    holdViol = 0;
    bpOn = 1'b1;
    sendDword(32'h0);
    runCmd("R10", 4, 1'b0, 1'b1, o, v);
    bpOn = 1'b0;
    check(holdViol == 0, "R10", "cmdReady low during pending write", 32'(holdViol), 32'd0);
  endtask

  task automatic tIgnored();
    int start;
    doReset();
    start = capN;
    sendDword(32'h0);
    sendDword(32'h1180_0001);  // other opcode
    sendDword(32'h0000_0100);
    sendDword(32'h5100_0001);  // load opcode, wrong client
    sendDword(32'h0000_0200);
    drain();
    check(capN == start, "R1", "non-command dwords write nothing", 32'(capN - start), 32'd0);
    check(orderErr == 1'b0 && lenErr == 1'b0, "R1", "no flags on other dwords",
          {30'b0, lenErr, orderErr}, 32'd0);
    sendDword(hdr(1, 1'b0, 1'b0));  // previous dword not a no-op
    sendDword(32'h0000_0300);
    sendDword(32'h0000_0077);
    drain();
    check(orderErr == 1'b1, "R9", "orderErr without no-op", 32'(orderErr), 32'd1);
    check(capN - start == 1, "R9", "write still issued", 32'(capN - start), 32'd1);
  endtask

  task automatic tBackToBack();
    doReset();
    sendDword(32'h0);
    sendDword(hdr(1, 1'b0, 1'b0));
    sendDword(32'h0000_0010);
    sendDword(32'h0000_0000);  // zero data must not count as a no-op
    sendDword(hdr(1, 1'b0, 1'b0));
    sendDword(32'h0000_0014);
    sendDword(32'h0000_0001);
    drain();
    check(orderErr == 1'b1, "R9", "payload zero not a no-op", 32'(orderErr), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tAbsolute();
    tRelative();
    tBothFlags();
    tSkipExact();
    tTooLong();
    tMax();
    tBackpressure();
    tIgnored();
    tBackToBack();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule